// File: doc/BRIEF.md
# Stretched-Level Pulse Crossing (Fast to Slow Clock)

This block moves single-cycle event pulses from a fast source clock domain into a slower destination clock domain without any handshake back to the sender. Each accepted source pulse is widened into a level that stays high for `STRETCH_CYC` source cycles. The level then stays low for a matching guard period, so the destination clock sees both edges of the level. The destination side captures the level and turns its rising edge into exactly one destination-clock-wide strobe.

The capture path depends on how the two clocks are related. When both clocks come from one source and are phase-related (`CLOCKS_RELATED = 1`), a single capture flop is used. When the clocks are unrelated, a chain of `SYNC_STAGES` flops is used, wired flop to flop with no logic between them. A pulse that arrives while a crossing is still in flight is merged into that crossing and raises a sticky overlap flag, so a dropped event is never silent.

`STRETCH_CYC` must be at least twice the destination-to-source period ratio, rounded up, plus one. For example, a 27 ns destination clock with an 8 ns source clock needs at least 9. The sender must space its pulses at least `2*STRETCH_CYC` source cycles apart to avoid merging.

Top module: `pulse_xfer_stretch`

## Requirements
- R1: While `rst_src_n` and `rst_dst_n` are low at their clock edges, every stage clears: `pulse_o` and `overlap_o` read 0 after reset.
- R2: Each accepted source pulse produces exactly one `pulse_o` high period, and that period is exactly one destination cycle long.
- R3: An accepted pulse opens a busy window. The stretched level is high for `STRETCH_CYC` source cycles and then low for `STRETCH_CYC` source cycles. A pulse sampled `2*STRETCH_CYC` or more source cycles after the previous accepted one is accepted as a new event.
- R4: A pulse sampled within `2*STRETCH_CYC-1` source cycles after an accepted one is merged. It produces no extra `pulse_o` and sets `overlap_o` to 1 from the next source edge.
- R5: `overlap_o` stays 1 until `rst_src_n` is asserted; later legal pulses do not clear it.
- R6: With `CLOCKS_RELATED = 1` the level crosses through one capture flop. Otherwise it crosses through `SYNC_STAGES` directly chained flops. In both modes the event count is preserved.
- R7: `pulse_o` rises no later than `STRETCH_CYC` source cycles plus `SYNC_STAGES + 3` destination cycles after the source pulse is sampled.
- R8: A train of pulses with random legal spacing, over a destination clock of unrelated phase, yields as many output pulses as input pulses and leaves `overlap_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_src_n | input | 1 | Source-domain synchronous reset, active low |
| pulse_i | input | 1 | Single-cycle event pulse, source domain |
| clk_dst | input | 1 | Slow destination clock |
| rst_dst_n | input | 1 | Destination-domain synchronous reset, active low |
| pulse_o | output | 1 | One-cycle event strobe, destination domain |
| overlap_o | output | 1 | Sticky flag: a pulse was merged into a busy crossing (source domain) |

## Verification
The bench places one pair of pulses exactly at the busy-window edge and another pair one cycle inside it. A design whose guard period is off by one would then either flag a legal pulse or lose an event without flagging it. It watches every destination cycle for a strobe lasting two cycles. That is what happens when the edge detector compares the wrong stages, or when a stretched level too short for the slow clock splits into two captures. Random-gap trains on an unrelated destination clock, run side by side with a phase-related instance, show any loss or duplication of events as a count mismatch. The sticky flag is checked to survive later legal traffic and to clear only on source reset.

// File: rtl/pxs_pkg.sv
// Package: shared types for the stretched-level pulse crossing.
package pxs_pkg;

    // Source-side sequencer phases: idle, level high, level low guard.
    typedef enum logic [1:0] {
        PXS_IDLE = 2'd0,
        PXS_HOLD = 2'd1,
        PXS_GAP  = 2'd2
    } pxs_phase_t;

endpackage

// File: rtl/pxs_stretcher.sv
// Module: pxs_stretcher
// Widens each accepted single-cycle pulse into a registered level that is
// high for STRETCH_CYC cycles, then holds it low for STRETCH_CYC cycles so
// that a slow sampler sees both edges. Pulses arriving inside that window
// are merged and raise a sticky overlap flag.
// Assumes: STRETCH_CYC >= 3; rst_n is synchronous to clk, active low.
module pxs_stretcher
    import pxs_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic level_o,
    output logic overlap_o
);

    localparam int unsigned CNT_W = $clog2(STRETCH_CYC);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(STRETCH_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(STRETCH_CYC - 2);

    pxs_phase_t       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             level_q;
    logic             overlap_q;
    logic             busy;

    assign busy = (phase_q != PXS_IDLE);

    // Next-phase and down-counter selection.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        case (phase_q)
            PXS_IDLE: begin
                if (pulse_i) begin
                    phase_d = PXS_HOLD;
                    cnt_d   = HOLD_LOAD;
                end
            end
            PXS_HOLD: begin
                if (cnt_q == '0) begin
                    phase_d = PXS_GAP;
                    cnt_d   = GAP_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PXS_GAP: begin
                if (cnt_q == '0) begin
                    phase_d = PXS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                phase_d = PXS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PXS_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Glitch-free crossing level, taken from its own flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= (phase_d == PXS_HOLD);
        end
    end

    // Sticky record of a pulse merged into a busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlap_q <= 1'b0;
        end else if (pulse_i && busy) begin
            overlap_q <= 1'b1;
        end
    end

    assign level_o   = level_q;
    assign overlap_o = overlap_q;

    // R5: the flag never falls outside reset.
    assert_overlap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_q |=> overlap_q);

    // R4: a pulse during the busy window is recorded.
    assert_merge_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && busy) |=> overlap_q);

    // R3: the level never lasts a single cycle, high or low.
    assert_level_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |=> level_q);

    assert_level_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_q) |=> !level_q);

endmodule

// File: rtl/pxs_sync_chain.sv
// Module: pxs_sync_chain
// Chain of STAGES flops clocked by the destination clock. Each stage feeds
// the next directly, with no logic in between. STAGES = 1 gives a plain
// capture flop for related clocks.
// Assumes: STAGES >= 1; rst_n is synchronous to clk, active low.
module pxs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the foreign-domain level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stage copies its predecessor directly.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end

            // R6: each later stage is a pure one-cycle delay of the previous.
            assert_stage_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (stage_q[i] == $past(stage_q[i-1])));
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pxs_edge_strobe.sv
// Module: pxs_edge_strobe
// Turns each rising edge of a synchronized level into one cycle of output.
// Assumes: level_i comes from a flop in this clock domain; rst_n is
// synchronous, active low.
module pxs_edge_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);

    logic prev_q;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign pulse_o = level_i & ~prev_q;

    // R2: the strobe never lasts two cycles.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/pulse_xfer_stretch.sv
// Module: pulse_xfer_stretch (top)
// Open-loop fast-to-slow pulse crossing. The source side stretches the pulse,
// the destination side synchronizes the level and then strobes on its
// rising edge.
// Assumes: STRETCH_CYC >= 2*ceil(Tdst/Tsrc)+1 and >= 3; SYNC_STAGES >= 2;
// input pulses spaced >= 2*STRETCH_CYC source cycles to avoid merging.
module pulse_xfer_stretch #(
    parameter int unsigned STRETCH_CYC    = 10,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          CLOCKS_RELATED = 1'b0
) (
    input  logic clk_src,
    input  logic rst_src_n,
    input  logic pulse_i,
    input  logic clk_dst,
    input  logic rst_dst_n,
    output logic pulse_o,
    output logic overlap_o
);

    localparam int unsigned CHAIN_LEN = CLOCKS_RELATED ? 1 : SYNC_STAGES;

    logic level_src;
    logic level_dst;

    pxs_stretcher #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_stretch (
        .clk       (clk_src),
        .rst_n     (rst_src_n),
        .pulse_i   (pulse_i),
        .level_o   (level_src),
        .overlap_o (overlap_o)
    );

    pxs_sync_chain #(
        .STAGES (CHAIN_LEN)
    ) u_sync (
        .clk   (clk_dst),
        .rst_n (rst_dst_n),
        .d_i   (level_src),
        .q_o   (level_dst)
    );

    pxs_edge_strobe u_strobe (
        .clk     (clk_dst),
        .rst_n   (rst_dst_n),
        .level_i (level_dst),
        .pulse_o (pulse_o)
    );

endmodule

// File: tb/pulse_xfer_stretch_tb_top.sv
`timescale 1ns/100ps
module pulse_xfer_stretch_tb_top;

    localparam int unsigned S      = 10;
    localparam int unsigned SYNC   = 2;
    localparam real         T_SRC  = 8.0;
    localparam real         T_DST  = 27.0;
    localparam real         T_REL  = 32.0;

    logic clk_src = 1'b0, clk_dst = 1'b0, clk_rel = 1'b0;
    logic rst_src_n = 1'b0, rst_dst_n = 1'b0;
    logic pulse_i = 1'b0;
    logic pulse_a, ovl_a, pulse_r, ovl_r;

    int checks = 0, errors = 0;
    int out_a = 0, out_r = 0, wide_a = 0, wide_r = 0;
    logic prev_a = 1'b0, prev_r = 1'b0;
    bit done = 1'b0;

    always #(T_SRC/2) clk_src = ~clk_src;
    always #(T_REL/2) clk_rel = ~clk_rel;
    initial begin
        #3.7;
        forever #(T_DST/2) clk_dst = ~clk_dst;
    end

    pulse_xfer_stretch #(.STRETCH_CYC(S), .SYNC_STAGES(SYNC), .CLOCKS_RELATED(1'b0)) dut_i (
        .clk_src(clk_src), .rst_src_n(rst_src_n), .pulse_i(pulse_i),
        .clk_dst(clk_dst), .rst_dst_n(rst_dst_n), .pulse_o(pulse_a), .overlap_o(ovl_a));

    pulse_xfer_stretch #(.STRETCH_CYC(S), .SYNC_STAGES(SYNC), .CLOCKS_RELATED(1'b1)) dut_rel_i (
        .clk_src(clk_src), .rst_src_n(rst_src_n), .pulse_i(pulse_i),
        .clk_dst(clk_rel), .rst_dst_n(rst_dst_n), .pulse_o(pulse_r), .overlap_o(ovl_r));

    // Output monitors sampled mid-cycle: count strobes, catch 2-cycle strobes.
    always @(negedge clk_dst) begin
        if (pulse_a) begin
            out_a++;
            if (prev_a) wide_a++;
        end
        prev_a = pulse_a;
    end
    always @(negedge clk_rel) begin
        if (pulse_r) begin
            out_r++;
            if (prev_r) wide_r++;
        end
        prev_r = pulse_r;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_src_n = 1'b0;
        rst_dst_n = 1'b0;
        pulse_i   = 1'b0;
        repeat (6) @(negedge clk_rel);
        rst_src_n = 1'b1;
        rst_dst_n = 1'b1;
        repeat (4) @(negedge clk_rel);
    endtask

    // One source-cycle pulse, sampled at the next rising source edge.
    task automatic send_pulse();
        @(negedge clk_src) pulse_i = 1'b1;
        @(negedge clk_src) pulse_i = 1'b0;
    endtask

    // Pulse sampled exactly gap source edges after the previous one.
    task automatic send_after(input int gap);
        repeat (gap - 1) @(negedge clk_src);
        pulse_i = 1'b1;
        @(negedge clk_src) pulse_i = 1'b0;
    endtask

    task automatic settle();
        repeat (2 * S + 40) @(negedge clk_src);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pulse_o async", int'(pulse_a), 0);
        check("R1 overlap_o async", int'(ovl_a), 0);
        check("R1 pulse_o related", int'(pulse_r), 0);
        check("R1 overlap_o related", int'(ovl_r), 0);
    endtask

    task automatic t_single();
        int a0 = out_a, r0 = out_r, waited = 0;
        send_pulse();
        // R7: bound = S source cycles plus SYNC+3 destination cycles.
        while (out_a == a0 && waited < int'((S * T_SRC + (SYNC + 3) * T_DST) / 1.0)) begin
            #1;
            waited++;
        end
        check("R7 strobe latency within bound", int'(out_a != a0), 1);
        settle();
        check("R2 single pulse count async", out_a - a0, 1);
        check("R6 single pulse count related", out_r - r0, 1);
    endtask

    task automatic t_train();
        int a0 = out_a, r0 = out_r, n = 25;
        send_pulse();
        for (int k = 1; k < n; k++) send_after(2 * S + int'($urandom_range(0, 17)));
        settle();
        check("R8 train count async", out_a - a0, n);
        check("R6 train count related", out_r - r0, n);
        check("R8 no overlap on legal train", int'(ovl_a), 0);
        check("R2 no wide strobe async", wide_a, 0);
        check("R2 no wide strobe related", wide_r, 0);
    endtask

    task automatic t_boundary();
        int a0, r0;
        do_reset();
        a0 = out_a; r0 = out_r;
        send_pulse();
        send_after(2 * S);
        settle();
        check("R3 gap 2*S accepted no overlap", int'(ovl_a), 0);
        check("R3 gap 2*S gives two strobes", out_a - a0, 2);
        check("R3 gap 2*S two strobes related", out_r - r0, 2);
        a0 = out_a; r0 = out_r;
        send_pulse();
        send_after(2 * S - 1);
        @(negedge clk_src);
        check("R4 gap 2*S-1 sets overlap", int'(ovl_a), 1);
        settle();
        check("R4 merged pulse gives one strobe", out_a - a0, 1);
        check("R4 merged pulse one strobe related", out_r - r0, 1);
    endtask

    task automatic t_overlap_close();
        int a0;
        do_reset();
        a0 = out_a;
        send_pulse();
        send_after(3);
        send_after(4);
        settle();
        check("R4 close pulses merged", out_a - a0, 1);
        check("R4 close pulses flagged", int'(ovl_a), 1);
        send_after(2 * S);
        send_after(2 * S + 5);
        settle();
        check("R5 overlap sticky after legal pulses", int'(ovl_a), 1);
        do_reset();
        check("R5 overlap cleared by source reset", int'(ovl_a), 0);
        check("R2 no wide strobe after overlap", wide_a + wide_r, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_train();
        t_boundary();
        t_overlap_close();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule